// File: doc/BRIEF.md
# Bit-Serial Isolation Target

This block is the device-side engine for a wired-OR contention scheme that picks one device out of several sharing a bus. At the start of a round the block captures an identifier string of `STR_BYTES` bytes. On each transfer cycle the host announces, the block presents the current bit of that string on one of two shared lines: the "one" line for a 1 and the "zero" line for a 0. The string is sent most significant byte first and most significant bit first within each byte. After a settle window the block samples the resolved bus. If its own bit is 0 while some other device drives the "one" line, its string is the smaller one, and it withdraws for the rest of the round.

A device that reaches the end of its string still contending holds the numerically largest string and is isolated. It stops driving both lines and waits for the host to hand it a 5-bit address. Once it has an address it takes no further part in any round, so the host can repeat rounds until every device has an address. The handshake strobes on the upper data lines are reduced to a single cycle-valid input. The electrical behaviour of the bus is modelled only as the resolved two-bit value fed back in.

Top module: `iso_target`

## Requirements
- R1: After reset the block is not contending, not lost, not isolated and not assigned. It drives neither line, and `id_out` is 0.
- R2: A `round_start` pulse in any state other than assigned captures `str_in` and starts contending from bit 0. Bit 0 is `str_in[STR_BYTES*8-1]`, the most significant bit of the most significant byte. Later bits follow in descending bit order.
- R3: A `cyc_valid` pulse while contending opens a drive window starting the next cycle and lasting `SETTLE` cycles. In that window `drv_one` is high if the current bit is 1, and `drv_zero` is high if it is 0. Outside drive windows both are low.
- R4: The bus is sampled in the last cycle of the drive window. If the own bit is 0 and `bus_in[1]` (the "one" line) is high, the block becomes lost. A lost block then ignores `cyc_valid` and drives nothing until the next round start.
- R5: A bit of 1 never causes a loss. A bit of 0 with `bus_in[1]` low lets the block move on to the next bit.
- R6: If all `STR_BYTES*8` bits pass without a loss, the block becomes isolated at the sample edge of the last bit. An isolated block drives neither line.
- R7: An `assign_valid` pulse while isolated stores `assign_id[4:0]` into `id_out` and moves the block to the assigned state.
- R8: An `assign_valid` pulse while not isolated has no effect on `id_out` or on the state.
- R9: An assigned block ignores `round_start`, `cyc_valid` and `assign_valid`. It keeps `id_out` and drives no line.
- R10: A block that lost a round rejoins contention on the next `round_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| round_start | input | 1 | Begin an isolation round and capture the string |
| str_in | input | STR_BYTES*8 | Identifier string captured at round start |
| cyc_valid | input | 1 | Host transfer cycle strobe |
| bus_in | input | 2 | Resolved wired-OR bus: [1] one line, [0] zero line |
| assign_valid | input | 1 | Host address hand-over strobe |
| assign_id | input | 5 | Address delivered by the host |
| drv_one | output | 1 | Drive the "one" line |
| drv_zero | output | 1 | Drive the "zero" line |
| contending | output | 1 | Block is still in the current round |
| lost | output | 1 | Block withdrew from the current round |
| isolated | output | 1 | Block won the round and awaits an address |
| assigned | output | 1 | Block holds an address |
| id_out | output | 5 | Assigned address |

## Verification
The bench aims at losses on the first bit and on the last bit, since an off-by-one bit counter would misplace the sample or declare a win one bit early. It also runs strings that are all ones or all zeros against quiet or heavy competition; a design that lost on a 1, or kept going on a 0 that met a 1, would show the wrong outcome there. It sends cycle strobes to a lost block and to an assigned block: a design that kept driving after losing would disturb later bits on the bus. Finally it hands out addresses while the block is not isolated, where a design that latched them would show a changed `id_out`.

// File: rtl/iso_pkg.sv
package iso_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CONTEND  = 3'd1,
    ST_DRIVE    = 3'd2,
    ST_LOST     = 3'd3,
    ST_ISOLATED = 3'd4,
    ST_ASSIGNED = 3'd5
  } iso_state_t;

  // A zero bit meeting an asserted one-line is the only losing case.
  function automatic logic loses_bit(input logic own_bit, input logic [1:0] bus);
    return (!own_bit) && bus[1];
  endfunction

  // Index of the bit that comes last in an MSB-first walk.
  function automatic int unsigned last_index(input int unsigned nbytes);
    return nbytes * 8 - 1;
  endfunction
endpackage

// File: rtl/iso_strreg.sv
module iso_strreg #(
  parameter int unsigned STR_BYTES = 2,
  localparam int unsigned STR_BITS = STR_BYTES * 8,
  localparam int unsigned IDX_W = (STR_BITS > 1) ? $clog2(STR_BITS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [STR_BITS-1:0] load_str,
  input  logic                advance,
  output logic                cur_bit,
  output logic                last_bit
);
  logic [STR_BITS-1:0] str_q;
  logic [IDX_W-1:0]    idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      str_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      str_q <= load_str;
      idx_q <= '0;
    end else if (advance) begin
      str_q <= {str_q[STR_BITS-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign cur_bit  = str_q[STR_BITS-1];
  assign last_bit = (idx_q == IDX_W'(iso_pkg::last_index(STR_BYTES)));

  // The controller must never step past the final bit.
  assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !last_bit);
endmodule

// File: rtl/iso_settle.sv
module iso_settle #(
  parameter int unsigned SETTLE = 2,
  localparam int unsigned CW = $clog2(SETTLE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic sample
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= '0;
    else if (run && !sample)
      cnt_q <= cnt_q + 1'b1;
  end

  assign sample = run && (cnt_q == CW'(SETTLE - 1));
endmodule

// File: rtl/iso_ctrl.sv
module iso_ctrl
  import iso_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       round_start,
  input  logic       cyc_valid,
  input  logic [1:0] bus_in,
  input  logic       assign_valid,
  input  logic [4:0] assign_id,
  input  logic       cur_bit,
  input  logic       last_bit,
  input  logic       sample,
  output logic       load,
  output logic       advance,
  output logic       settle_start,
  output logic       drive_en,
  output iso_state_t state,
  output logic [4:0] id_q
);
  iso_state_t state_d;
  logic       lose_now;

  assign lose_now = sample && loses_bit(cur_bit, bus_in);

  always_comb begin
    state_d      = state;
    load         = 1'b0;
    advance      = 1'b0;
    settle_start = 1'b0;
    unique case (state)
      ST_ASSIGNED: state_d = ST_ASSIGNED;
      ST_ISOLATED: begin
        if (assign_valid)
          state_d = ST_ASSIGNED;
        else if (round_start) begin
          load    = 1'b1;
          state_d = ST_CONTEND;
        end
      end
      ST_DRIVE: begin
        if (round_start) begin
          load    = 1'b1;
          state_d = ST_CONTEND;
        end else if (sample) begin
          if (lose_now)
            state_d = ST_LOST;
          else if (last_bit)
            state_d = ST_ISOLATED;
          else begin
            advance = 1'b1;
            state_d = ST_CONTEND;
          end
        end
      end
      ST_CONTEND: begin
        if (round_start)
          load = 1'b1;
        else if (cyc_valid) begin
          settle_start = 1'b1;
          state_d      = ST_DRIVE;
        end
      end
      default: begin
        if (round_start) begin
          load    = 1'b1;
          state_d = ST_CONTEND;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      id_q  <= '0;
    end else begin
      state <= state_d;
      if (state == ST_ISOLATED && assign_valid)
        id_q <= assign_id;
    end
  end

  assign drive_en = (state == ST_DRIVE);

  assert_loss_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRIVE && sample && !round_start && !cur_bit && bus_in[1])
      |=> (state == ST_LOST));

  assert_one_never_loses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRIVE && cur_bit) |=> (state != ST_LOST));

  assert_assigned_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ASSIGNED) |=> (state == ST_ASSIGNED));

  assert_id_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ASSIGNED && $past(state == ST_ASSIGNED)) |-> $stable(id_q));

  assert_id_only_when_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_ISOLATED) |=> (state == ST_ASSIGNED || id_q == $past(id_q)));
endmodule

// File: rtl/iso_target.sv
module iso_target
  import iso_pkg::*;
#(
  parameter int unsigned STR_BYTES = 2,
  parameter int unsigned SETTLE    = 2,
  localparam int unsigned STR_BITS = STR_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                round_start,
  input  logic [STR_BITS-1:0] str_in,
  input  logic                cyc_valid,
  input  logic [1:0]          bus_in,
  input  logic                assign_valid,
  input  logic [4:0]          assign_id,
  output logic                drv_one,
  output logic                drv_zero,
  output logic                contending,
  output logic                lost,
  output logic                isolated,
  output logic                assigned,
  output logic [4:0]          id_out
);
  logic       load, advance, settle_start, drive_en, sample;
  logic       cur_bit, last_bit;
  iso_state_t state;

  iso_strreg #(.STR_BYTES(STR_BYTES)) u_str (
    .clk(clk), .rst_n(rst_n), .load(load), .load_str(str_in),
    .advance(advance), .cur_bit(cur_bit), .last_bit(last_bit)
  );

  iso_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(settle_start), .run(drive_en),
    .sample(sample)
  );

  iso_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .round_start(round_start), .cyc_valid(cyc_valid),
    .bus_in(bus_in), .assign_valid(assign_valid), .assign_id(assign_id),
    .cur_bit(cur_bit), .last_bit(last_bit), .sample(sample),
    .load(load), .advance(advance), .settle_start(settle_start),
    .drive_en(drive_en), .state(state), .id_q(id_out)
  );

  assign drv_one    = drive_en && cur_bit;
  assign drv_zero   = drive_en && !cur_bit;
  assign contending = (state == ST_CONTEND) || (state == ST_DRIVE);
  assign lost       = (state == ST_LOST);
  assign isolated   = (state == ST_ISOLATED);
  assign assigned   = (state == ST_ASSIGNED);

  assert_quiet_when_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (assigned || lost || isolated) |-> !(drv_one || drv_zero));

  assert_drive_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && $past(drive_en)) |-> ($stable(drv_one) && $stable(drv_zero)));

  assert_own_drive_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_zero && sample) |-> bus_in[0]);
endmodule

// File: tb/iso_target_bench.sv
module iso_target_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned STR_BYTES  = 2;
  localparam int unsigned SETTLE     = 2;
  localparam int unsigned NB         = STR_BYTES * 8;
  localparam int unsigned NVEC       = 6;
  // Each entry: {string, mask of bits where another device drives the one-line}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'hA5C3, 16'h0000},
    {16'hFFFF, 16'hFFFF},
    {16'h0000, 16'h0000},
    {16'h7FFF, 16'h8000},
    {16'hFFFE, 16'h0001},
    {16'h1234, 16'h1300}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic round_start = 1'b0;
  logic [NB-1:0] str_in = '0;
  logic cyc_valid = 1'b0;
  logic oth_one = 1'b0, oth_zero = 1'b0;
  logic [1:0] bus_in;
  logic assign_valid = 1'b0;
  logic [4:0] assign_id = '0;
  logic drv_one, drv_zero, contending, lost, isolated, assigned;
  logic [4:0] id_out;
  int compared = 0, mismatched = 0, cycles = 0;

  assign bus_in = {drv_one | oth_one, drv_zero | oth_zero};

  always #(CLK_PERIOD / 2) clk = ~clk;

  iso_target #(.STR_BYTES(STR_BYTES), .SETTLE(SETTLE)) u_iso_target (
    .clk(clk), .rst_n(rst_n), .round_start(round_start), .str_in(str_in),
    .cyc_valid(cyc_valid), .bus_in(bus_in), .assign_valid(assign_valid),
    .assign_id(assign_id), .drv_one(drv_one), .drv_zero(drv_zero),
    .contending(contending), .lost(lost), .isolated(isolated),
    .assigned(assigned), .id_out(id_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic start_round(input logic [NB-1:0] s);
    @(negedge clk); round_start = 1'b1; str_in = s;
    @(negedge clk); round_start = 1'b0;
  endtask

  // Pulse one transfer cycle; report drive seen in window, leave at a negedge after the sample edge.
  task automatic do_cycle(input logic o1, output logic [1:0] drv_seen);
    @(negedge clk); cyc_valid = 1'b1; oth_one = o1; oth_zero = !o1;
    @(negedge clk); cyc_valid = 1'b0;
    drv_seen = {drv_one, drv_zero};
    repeat (SETTLE) @(negedge clk);
    oth_one = 1'b0; oth_zero = 1'b0;
  endtask

  initial begin
    logic [1:0] seen;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 status", {contending, lost, isolated, assigned}, 4'b0000);
    check("R1 drive", {drv_one, drv_zero}, 2'b00);
    check("R1 id", id_out, 5'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {contending, lost, isolated, assigned}, 4'b0000);

    for (int v = 0; v < NVEC; v++) begin
      logic [NB-1:0] s, m;
      int lose_at;
      s = VEC[v][31:16]; m = VEC[v][15:0];
      lose_at = -1;
      for (int i = 0; i < NB; i++)
        if (lose_at < 0 && !s[NB-1-i] && m[NB-1-i]) lose_at = i;
      start_round(s);
      check("R2 contending", contending, 1'b1);
      for (int i = 0; i < NB; i++) begin
        logic b;
        b = s[NB-1-i];
        do_cycle(m[NB-1-i], seen);
        if (lose_at >= 0 && i > lose_at) begin
          check("R4 lost quiet", seen, 2'b00);
          check("R4 stays lost", lost, 1'b1);
        end else begin
          check(i == 0 ? "R2 first bit MSB" : "R3 drive line", seen, {b, !b});
          if (i == lose_at)
            check("R4 loss", {lost, contending}, 2'b10);
          else if (i == NB - 1)
            check("R6 isolated", {isolated, contending}, 2'b10);
          else
            check("R5 continue", {contending, lost}, 2'b10);
        end
      end
      check("R6 quiet at end", {drv_one, drv_zero}, 2'b00);
    end

    // Last vector ended lost: address offer must be ignored.
    @(negedge clk); assign_valid = 1'b1; assign_id = 5'h0B;
    @(negedge clk); assign_valid = 1'b0;
    check("R8 ignored while lost", {assigned, id_out}, {1'b0, 5'd0});

    // Rejoin and win.
    start_round(16'h8001);
    check("R10 rejoin", {contending, lost}, 2'b10);
    for (int i = 0; i < NB; i++) do_cycle(1'b0, seen);
    check("R6 isolated after rejoin", isolated, 1'b1);
    @(negedge clk); assign_valid = 1'b1; assign_id = 5'h13;
    @(negedge clk); assign_valid = 1'b0;
    check("R7 assigned", {assigned, id_out}, {1'b1, 5'h13});

    // Assigned device sits out later rounds.
    start_round(16'hFFFF);
    check("R9 no rejoin", {assigned, contending}, 2'b10);
    do_cycle(1'b0, seen);
    check("R9 no drive", seen, 2'b00);
    @(negedge clk); assign_valid = 1'b1; assign_id = 5'h04;
    @(negedge clk); assign_valid = 1'b0;
    check("R9 id kept", id_out, 5'h13);

    finish_run();
  end
endmodule